// File: doc/BRIEF.md
# Timed Power-Up and Power-Down Sequencer

This block steers a set of output enables (regulator enables, a clock-output enable and general external power enables) through a small power-state machine. Its resting states are OFF, ON and SLEEP. A one-cycle request pulse starts a transition: power-up (OFF to ON), power-down (to OFF), sleep entry (ON to SLEEP) or wake (SLEEP to ON). Every transition runs as five numbered timeslots. Each timeslot lasts a nominal 2 ms, counted from a 1 ms tick that is derived from the system clock. Every sequenced output carries a 3-bit slot number, and the block switches it in the slot with that number.

Power-up and wake walk the slots upward and switch enables on. Power-down and sleep entry walk them downward and switch enables off. Sleep and wake affect only the outputs selected by a sleep mask. A power-up slot is held open until every output switched on in it reports power-good. If that wait runs past a limit, the block forces itself to OFF and raises a fault flag. Power-down, sleep entry and wake first wait a programmable number of milliseconds. Power-up starts at once. One output position is reserved for a converter that is not slot-sequenced: it turns on with the first power-up slot and turns off only when a power-down completes.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, state_code is 00000, every bit of en is 0, and irq_on, irq_off, irq_sleep and fault are all 0. In the OFF state every bit of en is 0.
- R2: An accepted power-up starts on the clock edge that samples req_on, with no delay. Slots T1..T5 follow one another, and each lasts SLOT_MS*CLK_HZ/1000 cycles. An output whose 3-bit field slot_cfg[3i+2:3i] equals k (1..5) switches on at the edge that opens Tk. An output whose field is 0, 6 or 7 is never switched on.
- R3: The output at index FIX_IDX ignores its slot field. It switches on at the edge that opens power-up T1, stays on through sleep, and switches off only when a power-down completes.
- R4: A power-down first waits dly_ms ms (dly_ms*CLK_HZ/1000 cycles, none when dly_ms is 0), showing state_code 00010. It then walks T5 down to T1 and switches off, at the start of Tk, every sequenced output whose field is k.
- R5: Sleep entry (only from ON) waits dly_ms ms and then walks T5..T1, switching off only outputs with sleep_mask bit 1. Wake (only from SLEEP) waits dly_ms ms and then walks T1..T5, switching the same outputs back on. Outputs with mask bit 0 are left alone by both.
- R6: state_code reads 00000 in OFF, 11111 in ON and 11100 in SLEEP. During a delay it reads 00010. During a slot it reads 10 followed by the 3-bit slot number.
- R7: On the clock edge that completes a transition, exactly one of irq_on, irq_off and irq_sleep rises for a single cycle, matching the state entered. Wake raises irq_on.
- R8: A power-up or wake slot does not close at its nominal end while any output switched on in that slot has pgood low. It closes on the first edge at which all of those outputs report pgood high.
- R9: If a power-up or wake slot is still waiting after 4*SLOT_MS ms, the block goes to OFF, clears every enable, sets fault and pulses irq_off. fault clears when the next power-up is accepted.
- R10: Requests arriving during a delay or a sequence are ignored, except req_off. req_on is honoured only in OFF, req_sleep only in ON and req_wake only in SLEEP.
- R11: req_off during any delay or sequence other than a power-down aborts it and starts a power-down. The downward walk begins from whatever enables are on at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| req_sleep | input | 1 | Sleep entry request pulse |
| req_wake | input | 1 | Wake request pulse |
| dly_ms | input | DLY_W | Delay in ms before power-down, sleep entry and wake |
| slot_cfg | input | 3*N_OUT | Slot number per output, 3 bits each, output i at bits 3i+2:3i |
| sleep_mask | input | N_OUT | Outputs switched by sleep and wake |
| pgood | input | N_OUT | Per-output ready report |
| en | output | N_OUT | Output enables |
| state_code | output | 5 | Current state code |
| irq_on | output | 1 | Pulse on entry to ON |
| irq_off | output | 1 | Pulse on entry to OFF |
| irq_sleep | output | 1 | Pulse on entry to SLEEP |
| fault | output | 1 | Sticky slot-timeout flag |

## Verification
The assertions assume that request inputs are single-cycle pulses and that slot_cfg, sleep_mask and dly_ms stay stable while a delay or a sequence is running. Under those conditions the enables, state codes and interrupts follow one legal path. The stimulus drives every input on the falling clock edge, holds each request high for exactly one cycle, and changes configuration only while the block rests in OFF or ON. pgood is held high except in the cases that stretch a slot on purpose or let it time out.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int N_OUT   = 7,
  parameter int FIX_IDX = 3,
  parameter int SLOT_MS = 2,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_on,
  input  logic               req_off,
  input  logic               req_sleep,
  input  logic               req_wake,
  input  logic [DLY_W-1:0]   dly_ms,
  input  logic [3*N_OUT-1:0] slot_cfg,
  input  logic [N_OUT-1:0]   sleep_mask,
  input  logic [N_OUT-1:0]   pgood,
  output logic [N_OUT-1:0]   en,
  output logic [4:0]         state_code,
  output logic               irq_on,
  output logic               irq_off,
  output logic               irq_sleep,
  output logic               fault
);
  localparam int DIV  = CLK_HZ / 1000;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TO_T = 4 * SLOT_MS;
  localparam int TMAX = (TO_T > (1 << DLY_W)) ? TO_T : (1 << DLY_W);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0]    C_LAST = CW'(DIV - 1);
  localparam logic [TW-1:0]    T_SLOT = TW'(SLOT_MS);
  localparam logic [TW-1:0]    T_TO   = TW'(TO_T);
  localparam logic [N_OUT-1:0] FIXB   = N_OUT'(1) << FIX_IDX;

  typedef enum logic [2:0] {S_OFF, S_ON, S_SLP, S_DLY, S_SEQ} st_t;
  typedef enum logic [1:0] {K_ON, K_OFF, K_SLP, K_WAK} kind_t;

  st_t              st;
  kind_t            kind, go_kind, ak;
  logic [2:0]       slot, tgt;
  logic [CW-1:0]    cnt_c;
  logic [TW-1:0]    cnt_t;
  logic [DLY_W-1:0] dly_q;

  function automatic logic [N_OUT-1:0] pick(input logic [3*N_OUT-1:0] cfg,
                                            input logic [N_OUT-1:0] lim,
                                            input logic [2:0] k);
    logic [N_OUT-1:0] m;
    for (int i = 0; i < N_OUT; i++)
      m[i] = (i != FIX_IDX) && (cfg[3*i +: 3] == k) && lim[i];
    return m;
  endfunction

  logic tick, off_go, on_go, slp_go, wk_go, go, afwd, enter, dly_end;
  logic ready, slot_end, timeout, adv, last;
  logic [N_OUT-1:0] lim, cur_m, am, en_nx;

  assign tick   = (cnt_c == C_LAST);
  assign off_go = req_off && (st == S_ON || st == S_SLP ||
                  ((st == S_DLY || st == S_SEQ) && kind != K_OFF));
  assign on_go  = req_on && st == S_OFF;
  assign slp_go = req_sleep && st == S_ON;
  assign wk_go  = req_wake && st == S_SLP;
  assign go     = off_go | on_go | slp_go | wk_go;

  always_comb begin
    if (off_go)      go_kind = K_OFF;
    else if (on_go)  go_kind = K_ON;
    else if (slp_go) go_kind = K_SLP;
    else             go_kind = K_WAK;
  end

  assign ak      = go ? go_kind : kind;
  assign afwd    = (ak == K_ON) || (ak == K_WAK);
  assign lim     = (ak == K_SLP || ak == K_WAK) ? sleep_mask : '1;
  assign dly_end = st == S_DLY && tick && cnt_t == TW'(dly_q) - TW'(1);
  assign enter   = (go && (go_kind == K_ON || dly_ms == '0)) || (!go && dly_end);

  assign cur_m    = pick(slot_cfg, lim, slot);
  assign ready    = !afwd || &(pgood | ~cur_m);
  assign slot_end = st == S_SEQ && ((tick && cnt_t == T_SLOT - TW'(1)) || cnt_t >= T_SLOT);
  assign timeout  = st == S_SEQ && !ready && tick && cnt_t == T_TO - TW'(1);
  assign adv      = !go && slot_end && ready;
  assign last     = afwd ? (slot == 3'd5) : (slot == 3'd1);

  always_comb begin
    if (enter)     tgt = afwd ? 3'd1 : 3'd5;
    else if (afwd) tgt = slot + 3'd1;
    else           tgt = slot - 3'd1;
  end

  assign am    = pick(slot_cfg, lim, tgt);
  assign en_nx = afwd ? (en | am | ((ak == K_ON) ? FIXB : '0)) : (en & ~am);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      kind      <= K_OFF;
      slot      <= 3'd1;
      cnt_c     <= '0;
      cnt_t     <= '0;
      dly_q     <= '0;
      en        <= '0;
      fault     <= 1'b0;
      irq_on    <= 1'b0;
      irq_off   <= 1'b0;
      irq_sleep <= 1'b0;
    end else begin
      irq_on    <= 1'b0;
      irq_off   <= 1'b0;
      irq_sleep <= 1'b0;
      cnt_c <= tick ? '0 : cnt_c + 1'b1;
      if (tick && cnt_t != '1) cnt_t <= cnt_t + 1'b1;
      if (go) begin
        kind  <= go_kind;
        dly_q <= dly_ms;
        cnt_c <= '0;
        cnt_t <= '0;
        if (on_go) fault <= 1'b0;
      end
      if (enter) begin
        st    <= S_SEQ;
        slot  <= tgt;
        en    <= en_nx;
        cnt_c <= '0;
        cnt_t <= '0;
      end else if (go) begin
        st <= S_DLY;
      end else if (timeout) begin
        st      <= S_OFF;
        en      <= '0;
        fault   <= 1'b1;
        irq_off <= 1'b1;
      end else if (adv) begin
        cnt_c <= '0;
        cnt_t <= '0;
        if (last) begin
          case (kind)
            K_OFF: begin st <= S_OFF; en <= '0; irq_off <= 1'b1; end
            K_SLP: begin st <= S_SLP; irq_sleep <= 1'b1; end
            default: begin st <= S_ON; irq_on <= 1'b1; end
          endcase
        end else begin
          slot <= tgt;
          en   <= en_nx;
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_OFF:   state_code = 5'b00000;
      S_ON:    state_code = 5'b11111;
      S_SLP:   state_code = 5'b11100;
      S_DLY:   state_code = 5'b00010;
      default: state_code = {2'b10, slot};
    endcase
  end
endmodule

module pwr_seq_ctrl_chk #(
  parameter int N_OUT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] en,
  input logic [4:0]       state_code,
  input logic             irq_on,
  input logic             irq_off,
  input logic             irq_sleep,
  input logic             fault
);
  a_r1_off_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 5'b00000 |-> en == '0);

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_code inside {5'b00000, 5'b11111, 5'b11100, 5'b00010, [5'b10001:5'b10101]});

  a_r7_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_on, irq_off, irq_sleep}));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_on || irq_off || irq_sleep) |=> !(irq_on || irq_off || irq_sleep));

  a_r7_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_on |-> state_code == 5'b11111);

  a_r7_sleep_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sleep |-> state_code == 5'b11100);

  a_r7_off_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |-> state_code == 5'b00000);

  a_r9_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (en == '0 && state_code == 5'b00000 && irq_off));

  a_r10_on_exits: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 5'b11111 |=> state_code inside {5'b11111, 5'b00010, 5'b10101});
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N_OUT(N_OUT)) u_chk (.*);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int CLK_T = 10;
  localparam int N     = 6;
  localparam int FX    = 3;
  localparam int MS    = 4;
  localparam int SL    = 2 * MS;
  localparam logic [N-1:0] FXB = 6'b001000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_on = 0, req_off = 0, req_sleep = 0, req_wake = 0;
  logic [7:0] dly_ms = '0;
  logic [3*N-1:0] slot_cfg = '0;
  logic [N-1:0] sleep_mask = '0, pgood = '1;
  logic [N-1:0] en;
  logic [4:0] state_code;
  logic irq_on, irq_off, irq_sleep, fault;

  int n_run = 0, n_fail = 0, c = 0;

  always #(CLK_T/2) clk = ~clk;

  pwr_seq_ctrl #(.CLK_HZ(4000), .N_OUT(N), .FIX_IDX(FX), .SLOT_MS(2), .DLY_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .req_sleep(req_sleep), .req_wake(req_wake), .dly_ms(dly_ms),
    .slot_cfg(slot_cfg), .sleep_mask(sleep_mask), .pgood(pgood),
    .en(en), .state_code(state_code), .irq_on(irq_on), .irq_off(irq_off),
    .irq_sleep(irq_sleep), .fault(fault));

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s at c=%0d: got %h expected %h", tag, c, a, e);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    c += n;
  endtask

  task automatic to(input int t);
    if (t > c) adv(t - c);
  endtask

  task automatic pulse(input int w);
    case (w)
      0: req_on = 1'b1;
      1: req_off = 1'b1;
      2: req_sleep = 1'b1;
      default: req_wake = 1'b1;
    endcase
    adv(1);
    req_on = 0; req_off = 0; req_sleep = 0; req_wake = 0;
  endtask

  function automatic logic [N-1:0] act(input int lo, input int hi, input logic [N-1:0] lim);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int v = int'(slot_cfg[3*i +: 3]);
      r[i] = (i != FX) && v >= lo && v <= hi && lim[i];
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    adv(2);
    chk("R1 reset code", 32'(state_code), 0);
    chk("R1 reset en", 32'(en), 0);
    chk("R1 reset flags", {irq_on, irq_off, irq_sleep, fault}, 0);
    rst_n = 1'b1;
    adv(2);
    pulse(1);
    chk("R10 off in OFF code", 32'(state_code), 0);
    adv(1);
    chk("R10 off in OFF irq", 32'(irq_off), 0);

    for (int p = 0; p < 8; p++) begin
      for (int qi = 0; qi < 2; qi++) begin
        int q = qi ? 3 : 1;
        int d;
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) slot_cfg[3*i +: 3] = 3'((p + q * i) % 8);
        sleep_mask = 6'((p * 11 + q * 5) % 64);
        m = sleep_mask;
        d = (p + qi) % 3;
        dly_ms = 8'(d);
        pulse(0); c = 0;
        for (int s = 1; s <= 5; s++) begin
          to((s - 1) * SL + 3);
          chk("R2 R3 on en", 32'(en), 32'(FXB | act(1, s, '1)));
          chk("R6 on code", 32'(state_code), 32'(5'b10000 | s));
        end
        to(5 * SL - 1);
        chk("R7 no early irq", 32'(irq_on), 0);
        to(5 * SL);
        chk("R6 on state", 32'(state_code), 32'h1f);
        chk("R7 irq_on", 32'(irq_on), 1);
        adv(1);
        chk("R7 irq_on width", 32'(irq_on), 0);

        pulse(2); c = 0;
        if (d > 0) begin
          to(d * MS - 1);
          chk("R4 R5 sleep delay code", 32'(state_code), 32'h02);
          chk("R5 sleep delay en", 32'(en), 32'(FXB | act(1, 5, '1)));
        end
        for (int j = 0; j < 5; j++) begin
          to(d * MS + j * SL + 3);
          chk("R5 R3 sleep en", 32'(en), 32'(FXB | act(1, 5, ~m) | act(1, 4 - j, m)));
        end
        to(d * MS + 5 * SL);
        chk("R6 sleep state", 32'(state_code), 32'h1c);
        chk("R7 irq_sleep", 32'(irq_sleep), 1);

        pulse(3); c = 0;
        for (int s = 1; s <= 5; s++) begin
          to(d * MS + (s - 1) * SL + 3);
          chk("R5 wake en", 32'(en), 32'(FXB | act(1, 5, ~m) | act(1, s, m)));
        end
        to(d * MS + 5 * SL);
        chk("R7 wake irq_on", {27'd0, state_code, irq_on}, {27'd0, 5'h1f, 1'b1});

        pulse(1); c = 0;
        if (d > 0) begin
          to(d * MS - 1);
          chk("R4 off delay code", 32'(state_code), 32'h02);
        end
        for (int j = 0; j < 5; j++) begin
          to(d * MS + j * SL + 3);
          chk("R4 R3 off en", 32'(en), 32'(FXB | act(1, 4 - j, '1)));
          chk("R6 off code", 32'(state_code), 32'(5'b10000 | (5 - j)));
        end
        to(d * MS + 5 * SL);
        chk("R4 off done", {27'd0, state_code, 32'(en) != 0}, 0);
        chk("R7 irq_off", 32'(irq_off), 1);
      end
    end

    slot_cfg = {3'd0, 3'd3, 3'd1, 3'd5, 3'd1, 3'd2};
    dly_ms = 8'd0;
    pulse(0); c = 0;
    to(9); pulse(2); pulse(0);
    to(19);
    chk("R10 seq ignores req", 32'(state_code), 32'h13);
    to(40);
    chk("R10 on reached", {27'd0, state_code, irq_on}, {27'd0, 5'h1f, 1'b1});
    pulse(3); pulse(0); adv(1);
    chk("R10 ON ignores wake/on code", 32'(state_code), 32'h1f);
    chk("R10 ON ignores wake/on en", 32'(en), 32'(FXB | act(1, 5, '1)));
    pulse(1); c = 0;
    to(40);
    chk("R4 off zero delay", 32'(state_code), 0);

    pgood = 6'b111110;
    pulse(0); c = 0;
    to(21);
    chk("R8 slot held", 32'(state_code), 32'h12);
    pgood = '1;
    adv(1);
    chk("R8 slot released", 32'(state_code), 32'h13);
    to(22 + 3 * SL);
    chk("R8 on after stretch", {27'd0, state_code, irq_on}, {27'd0, 5'h1f, 1'b1});
    pulse(1); c = 0;
    to(40);

    pgood = 6'b111110;
    pulse(0); c = 0;
    to(39);
    chk("R9 before timeout", {27'd0, state_code, fault}, {27'd0, 5'h12, 1'b0});
    to(40);
    chk("R9 timeout code fault", {27'd0, state_code, fault}, {27'd0, 5'h00, 1'b1});
    chk("R9 timeout en irq", {25'd0, en, irq_off}, {25'd0, 6'd0, 1'b1});
    pgood = '1;
    pulse(0); c = 0;
    chk("R9 fault cleared", 32'(fault), 0);
    to(40);
    chk("R9 on after fault", 32'(state_code), 32'h1f);
    pulse(1); c = 0;
    to(40);

    pulse(0); c = 0;
    to(12); pulse(1);
    to(16);
    chk("R11 abort code", 32'(state_code), 32'h15);
    chk("R11 abort en", 32'(en), 32'(FXB | act(1, 2, '1)));
    to(13 + 3 * SL + 3);
    chk("R11 abort slot2 en", 32'(en), 32'(FXB | act(1, 1, '1)));
    to(13 + 5 * SL);
    chk("R11 abort done", {26'd0, state_code, irq_off}, {26'd0, 5'h00, 1'b1});
    chk("R11 abort en off", 32'(en), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule